// File: doc/BRIEF.md
# Out-of-Order Dispatch Admission Stage

This stage sits between the decoded-instruction queue and the out-of-order backend. Each cycle it looks at up to `LANES` instructions at the head of the queue, oldest in lane 0. It decides how many of them may enter the backend in this cycle. An instruction is admitted only if five things hold: the current dispatch group has room under the micro-op width, the reorder buffer has an entry for each of its micro-ops, the rename pool has a free physical register for each of its destinations, the scheduler buffer has an entry for each micro-op, and the load or store queue has a slot when it is a memory operation. Admission is strictly in program order. The first instruction that fails a check blocks every younger one.

The physical-register pool is tracked inside the block. It starts full at `REG_FILE_SIZE` and shrinks by the destinations dispatched. It grows only when the backend reports a retiring instruction's registers on the in-order retire input. A `REG_FILE_SIZE` of zero selects an unbounded pool, and the register check then never stalls. Reorder-buffer, scheduler and load/store space arrive as free counts that already reflect every earlier dispatch. The block also counts stall cycles by cause, and it keeps a histogram of micro-ops dispatched per cycle.

The input is a queue-head valid/ready interface. `in_valid` must be a contiguous run starting at lane 0, and lane fields must stay stable while valid. `in_ready[i]` is high exactly when lane i is taken this cycle, which means the queue pops `$countones(in_ready)` entries at the next rising edge. `in_ready` depends combinationally on `in_valid` and the lane fields. The backend has no back-pressure other than its free counts.

Top module: `dispatch_admit`

## Requirements
- R1: Lanes are admitted as a contiguous run from lane 0. An instruction that is invalid or stalled blocks every younger lane in the same cycle, and `in_ready` is never high for an invalid lane.
- R2: The micro-ops admitted in one cycle total at most `DISP_W`. The only exception is an instruction in lane 0, which is always admitted alone if every other check passes, even when its own count exceeds `DISP_W`.
- R3: Admitted instructions consume one reorder-buffer entry per micro-op. A lane stalls when the micro-ops of the older admitted lanes plus its own exceed `rob_free`.
- R4: A lane stalls when the destinations of the older admitted lanes plus its own exceed the current register pool. With `REG_FILE_SIZE` = 0 this check never stalls. `disp_dsts` reports the destinations admitted this cycle.
- R5: Each micro-op takes one scheduler entry, checked against `sched_free`. `in_kind` bit 0 marks a load and takes one `lq_free` slot. `in_kind` bit 1 marks a store and takes one `sq_free` slot. Both bits set takes one of each.
- R6: The register pool resets to `REG_FILE_SIZE`. At each rising edge it becomes its previous value minus `disp_dsts`, plus `ret_dsts` when `ret_valid` is high.
- R7: `stall_cause` names the first refused valid lane's reason, or 0 when no valid lane is refused. The codes are 1 reorder buffer, 2 registers, 3 scheduler, 4 load queue, 5 store queue and 6 group width. When several reasons apply, the lowest code wins.
- R8: At each rising edge with a nonzero `stall_cause` code c, the counter at `stall_cnt[(c-1)*CNT_W +: CNT_W]` increments by one. All stall counters reset to zero.
- R9: Every cycle out of reset increments exactly one histogram counter, at `hist_cnt[k*CNT_W +: CNT_W]`. Here k is the number of micro-ops admitted that cycle, clamped to `DISP_W`.
- R10: Under reset all counters read zero and `in_ready` depends only on the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | LANES | Queue-head lane valid, contiguous from lane 0 |
| in_uops | input | LANES*UOP_W | Micro-op count per lane |
| in_dsts | input | LANES*DST_W | Destination register count per lane |
| in_kind | input | LANES*2 | Per lane: bit 0 load, bit 1 store |
| in_ready | output | LANES | Lane admitted this cycle |
| rob_free | input | FREE_W | Free reorder-buffer entries |
| sched_free | input | FREE_W | Free scheduler entries |
| lq_free | input | FREE_W | Free load-queue slots |
| sq_free | input | FREE_W | Free store-queue slots |
| ret_valid | input | 1 | A retiring instruction returns registers |
| ret_dsts | input | DST_W | Registers returned by that instruction |
| disp_uops | output | SUM_W | Micro-ops admitted this cycle |
| disp_dsts | output | DSUM_W | Destinations admitted this cycle |
| stall_cause | output | 3 | Current stall reason code |
| reg_free_cnt | output | RCW | Current register pool level |
| stall_cnt | output | 6*CNT_W | Stall counters per cause |
| hist_cnt | output | (DISP_W+1)*CNT_W | Micro-ops-per-cycle histogram |

## Verification
Four outputs are combinational in the inputs and the current pool level, so they are due in the same cycle as the stimulus: `in_ready`, `disp_uops`, `disp_dsts` and `stall_cause`. The pool level, stall counters and histogram change only at the following rising edge. The bench drives each stimulus at a falling edge and samples the same-cycle results 1 ns later. It then advances its own arithmetic model and compares the registered results at the next falling edge, one full edge later. The sweeps cover two-lane micro-op pairs against every reorder-buffer level, all load/store kind patterns against small queue levels, and every scheduler level. A drained pool, an oversized head instruction and a long mixed random run round these out.

// File: rtl/dispatch_admit_pkg.sv
package dispatch_admit_pkg;

  // Stall reason codes; lower code has higher priority.
  typedef enum logic [2:0] {
    CZ_NONE  = 3'd0,
    CZ_ROB   = 3'd1,
    CZ_REG   = 3'd2,
    CZ_SCHED = 3'd3,
    CZ_LDQ   = 3'd4,
    CZ_STQ   = 3'd5,
    CZ_GROUP = 3'd6
  } stall_cause_e;

  localparam int NUM_CAUSES = 6;

  // Kind bit positions within a lane's 2-bit kind field.
  localparam int KIND_LD_BIT = 0;
  localparam int KIND_ST_BIT = 1;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/dispatch_lane_check.sv
module dispatch_lane_check
  import dispatch_admit_pkg::*;
#(
  parameter int CMP_W       = 8,
  parameter int DISP_W      = 4,
  parameter bit IS_HEAD     = 1'b0,
  parameter bit REG_BOUNDED = 1'b1
) (
  input  logic [CMP_W-1:0] base_uops,
  input  logic [CMP_W-1:0] base_dsts,
  input  logic [CMP_W-1:0] base_lds,
  input  logic [CMP_W-1:0] base_sts,
  input  logic [CMP_W-1:0] lane_uops,
  input  logic [CMP_W-1:0] lane_dsts,
  input  logic             lane_ld,
  input  logic             lane_st,
  input  logic [CMP_W-1:0] rob_room,
  input  logic [CMP_W-1:0] reg_room,
  input  logic [CMP_W-1:0] sched_room,
  input  logic [CMP_W-1:0] lq_room,
  input  logic [CMP_W-1:0] sq_room,
  output logic             lane_ok,
  output logic [2:0]       lane_cause
);

  logic [CMP_W-1:0] need_uops;
  logic [CMP_W-1:0] need_lds;
  logic [CMP_W-1:0] need_sts;
  logic rob_short, reg_short, sched_short, lq_short, sq_short, grp_short;
  stall_cause_e cause;

  assign need_uops = base_uops + lane_uops;
  assign need_lds  = base_lds + CMP_W'(lane_ld);
  assign need_sts  = base_sts + CMP_W'(lane_st);

  assign rob_short   = need_uops > rob_room;
  assign sched_short = need_uops > sched_room;
  assign lq_short    = lane_ld && (need_lds > lq_room);
  assign sq_short    = lane_st && (need_sts > sq_room);

  generate
    if (IS_HEAD) begin : g_head
      // The head of an empty group may exceed the width on its own.
      assign grp_short = 1'b0;
    end else begin : g_tail
      assign grp_short = need_uops > CMP_W'(DISP_W);
    end

    if (REG_BOUNDED) begin : g_reg_bounded
      assign reg_short = (base_dsts + lane_dsts) > reg_room;
    end else begin : g_reg_unbounded
      logic unused_reg_inputs;
      assign unused_reg_inputs = ^{base_dsts, lane_dsts, reg_room};
      assign reg_short = 1'b0;
    end
  endgenerate

  always_comb begin
    if (rob_short)        cause = CZ_ROB;
    else if (reg_short)   cause = CZ_REG;
    else if (sched_short) cause = CZ_SCHED;
    else if (lq_short)    cause = CZ_LDQ;
    else if (sq_short)    cause = CZ_STQ;
    else if (grp_short)   cause = CZ_GROUP;
    else                  cause = CZ_NONE;
  end

  assign lane_cause = cause;
  assign lane_ok    = (cause == CZ_NONE);

endmodule

// File: rtl/dispatch_reg_pool.sv
module dispatch_reg_pool #(
  parameter int REG_FILE_SIZE = 8,
  parameter int DSUM_W        = 5,
  parameter int DST_W         = 2,
  localparam int RCW = (REG_FILE_SIZE == 0) ? 1 : $clog2(REG_FILE_SIZE + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DSUM_W-1:0] alloc,
  input  logic              rel_valid,
  input  logic [DST_W-1:0]  rel,
  output logic [RCW-1:0]    free_cnt
);

  generate
    if (REG_FILE_SIZE != 0) begin : g_bounded
      logic [RCW-1:0] free_q;
      logic [RCW-1:0] give_back;

      assign give_back = rel_valid ? RCW'(rel) : '0;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) free_q <= RCW'(REG_FILE_SIZE);
        else        free_q <= free_q - RCW'(alloc) + give_back;
      end

      assign free_cnt = free_q;
    end else begin : g_unbounded
      logic unused_pool_inputs;
      assign unused_pool_inputs = ^{clk, rst_n, alloc, rel_valid, rel};
      assign free_cnt = '0;
    end
  endgenerate

endmodule

// File: rtl/dispatch_stats.sv
module dispatch_stats
  import dispatch_admit_pkg::*;
#(
  parameter int DISP_W = 4,
  parameter int SUM_W  = 6,
  parameter int CNT_W  = 16,
  localparam int BINS  = DISP_W + 1,
  localparam int BIN_W = $clog2(BINS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [2:0]                 cause,
  input  logic [SUM_W-1:0]           disp_uops,
  output logic [NUM_CAUSES*CNT_W-1:0] stall_cnt,
  output logic [BINS*CNT_W-1:0]      hist_cnt
);

  logic [BIN_W-1:0] bin;

  assign bin = (disp_uops > SUM_W'(DISP_W)) ? BIN_W'(DISP_W) : BIN_W'(disp_uops);

  generate
    for (genvar g = 0; g < NUM_CAUSES; g++) begin : g_stall
      logic [CNT_W-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  cnt_q <= '0;
        else if (cause == 3'(g + 1)) cnt_q <= cnt_q + 1'b1;
      end
      assign stall_cnt[g*CNT_W +: CNT_W] = cnt_q;
    end

    for (genvar b = 0; b < BINS; b++) begin : g_hist
      logic [CNT_W-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  cnt_q <= '0;
        else if (bin == BIN_W'(b))   cnt_q <= cnt_q + 1'b1;
      end
      assign hist_cnt[b*CNT_W +: CNT_W] = cnt_q;
    end
  endgenerate

endmodule

// File: rtl/dispatch_admit.sv
module dispatch_admit
  import dispatch_admit_pkg::*;
#(
  parameter int LANES         = 4,
  parameter int DISP_W        = 4,
  parameter int UOP_W         = 3,
  parameter int DST_W         = 2,
  parameter int FREE_W        = 4,
  parameter int REG_FILE_SIZE = 8,
  parameter int CNT_W         = 16,
  localparam int SUM_W  = UOP_W + $clog2(LANES) + 1,
  localparam int DSUM_W = DST_W + $clog2(LANES) + 1,
  localparam int RCW    = (REG_FILE_SIZE == 0) ? 1 : $clog2(REG_FILE_SIZE + 1)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [LANES-1:0]               in_valid,
  input  logic [LANES*UOP_W-1:0]         in_uops,
  input  logic [LANES*DST_W-1:0]         in_dsts,
  input  logic [LANES*2-1:0]             in_kind,
  output logic [LANES-1:0]               in_ready,
  input  logic [FREE_W-1:0]              rob_free,
  input  logic [FREE_W-1:0]              sched_free,
  input  logic [FREE_W-1:0]              lq_free,
  input  logic [FREE_W-1:0]              sq_free,
  input  logic                           ret_valid,
  input  logic [DST_W-1:0]               ret_dsts,
  output logic [SUM_W-1:0]               disp_uops,
  output logic [DSUM_W-1:0]              disp_dsts,
  output logic [2:0]                     stall_cause,
  output logic [RCW-1:0]                 reg_free_cnt,
  output logic [NUM_CAUSES*CNT_W-1:0]    stall_cnt,
  output logic [(DISP_W+1)*CNT_W-1:0]    hist_cnt
);

  localparam int CMP_W = max3(max3(SUM_W, DSUM_W, FREE_W), RCW, 1) + 1;

  // Per-lane fields widened to the comparison width.
  logic [CMP_W-1:0] lane_u [LANES];
  logic [CMP_W-1:0] lane_d [LANES];
  logic             lane_ld [LANES];
  logic             lane_st [LANES];

  // Running totals of all older lanes.
  logic [CMP_W-1:0] base_u [LANES];
  logic [CMP_W-1:0] base_d [LANES];
  logic [CMP_W-1:0] base_l [LANES];
  logic [CMP_W-1:0] base_s [LANES];

  logic [LANES-1:0] lane_ok;
  logic [2:0]       lane_cause [LANES];

  logic [RCW-1:0]   pool_free;
  logic [CMP_W-1:0] rob_room, reg_room, sched_room, lq_room, sq_room;

  logic [LANES-1:0] accept;
  logic [2:0]       cause_now;
  logic [CMP_W-1:0] took_u, took_d;

  assign rob_room   = CMP_W'(rob_free);
  assign sched_room = CMP_W'(sched_free);
  assign lq_room    = CMP_W'(lq_free);
  assign sq_room    = CMP_W'(sq_free);
  assign reg_room   = CMP_W'(pool_free);

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_fields
      assign lane_u[i]  = CMP_W'(in_uops[i*UOP_W +: UOP_W]);
      assign lane_d[i]  = CMP_W'(in_dsts[i*DST_W +: DST_W]);
      assign lane_ld[i] = in_kind[i*2 + KIND_LD_BIT];
      assign lane_st[i] = in_kind[i*2 + KIND_ST_BIT];
    end
  endgenerate

  // Prefix totals: lane i sees what lanes 0..i-1 would consume.
  always_comb begin
    logic [CMP_W-1:0] acc_u, acc_d, acc_l, acc_s;
    acc_u = '0;
    acc_d = '0;
    acc_l = '0;
    acc_s = '0;
    for (int i = 0; i < LANES; i++) begin
      base_u[i] = acc_u;
      base_d[i] = acc_d;
      base_l[i] = acc_l;
      base_s[i] = acc_s;
      acc_u = acc_u + lane_u[i];
      acc_d = acc_d + lane_d[i];
      acc_l = acc_l + CMP_W'(lane_ld[i]);
      acc_s = acc_s + CMP_W'(lane_st[i]);
    end
  end

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      dispatch_lane_check #(
        .CMP_W      (CMP_W),
        .DISP_W     (DISP_W),
        .IS_HEAD    (i == 0),
        .REG_BOUNDED(REG_FILE_SIZE != 0)
      ) u_check (
        .base_uops (base_u[i]),
        .base_dsts (base_d[i]),
        .base_lds  (base_l[i]),
        .base_sts  (base_s[i]),
        .lane_uops (lane_u[i]),
        .lane_dsts (lane_d[i]),
        .lane_ld   (lane_ld[i]),
        .lane_st   (lane_st[i]),
        .rob_room  (rob_room),
        .reg_room  (reg_room),
        .sched_room(sched_room),
        .lq_room   (lq_room),
        .sq_room   (sq_room),
        .lane_ok   (lane_ok[i]),
        .lane_cause(lane_cause[i])
      );
    end
  endgenerate

  // In-order admission: the first refused or empty lane closes the group.
  always_comb begin
    logic live;
    live      = 1'b1;
    accept    = '0;
    cause_now = CZ_NONE;
    took_u    = '0;
    took_d    = '0;
    for (int i = 0; i < LANES; i++) begin
      if (live && in_valid[i]) begin
        if (lane_ok[i]) begin
          accept[i] = 1'b1;
          took_u    = took_u + lane_u[i];
          took_d    = took_d + lane_d[i];
        end else begin
          cause_now = lane_cause[i];
          live      = 1'b0;
        end
      end else begin
        live = 1'b0;
      end
    end
  end

  assign in_ready    = accept;
  assign disp_uops   = SUM_W'(took_u);
  assign disp_dsts   = DSUM_W'(took_d);
  assign stall_cause = cause_now;

  dispatch_reg_pool #(
    .REG_FILE_SIZE(REG_FILE_SIZE),
    .DSUM_W       (DSUM_W),
    .DST_W        (DST_W)
  ) u_pool (
    .clk      (clk),
    .rst_n    (rst_n),
    .alloc    (disp_dsts),
    .rel_valid(ret_valid),
    .rel      (ret_dsts),
    .free_cnt (pool_free)
  );

  assign reg_free_cnt = pool_free;

  dispatch_stats #(
    .DISP_W(DISP_W),
    .SUM_W (SUM_W),
    .CNT_W (CNT_W)
  ) u_stats (
    .clk      (clk),
    .rst_n    (rst_n),
    .cause    (cause_now),
    .disp_uops(disp_uops),
    .stall_cnt(stall_cnt),
    .hist_cnt (hist_cnt)
  );

endmodule

// File: rtl/dispatch_admit_chk.sv
module dispatch_admit_chk
  import dispatch_admit_pkg::*;
#(
  parameter int LANES         = 4,
  parameter int DISP_W        = 4,
  parameter int SUM_W         = 6,
  parameter int RCW           = 4,
  parameter int REG_FILE_SIZE = 8,
  parameter int CNT_W         = 16
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [LANES-1:0]            in_valid,
  input logic [LANES-1:0]            in_ready,
  input logic [SUM_W-1:0]            disp_uops,
  input logic [2:0]                  stall_cause,
  input logic [RCW-1:0]              reg_free_cnt,
  input logic [NUM_CAUSES*CNT_W-1:0] stall_cnt
);

  // R1: admitted lanes form a run from lane 0.
  assert_ready_prefix_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (LANES'(in_ready + 1'b1) & in_ready) == '0);

  // R1: never admit an empty lane.
  assert_ready_needs_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready & ~in_valid) == '0);

  // R2: group width respected unless the head goes alone.
  assert_group_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready != '0) |-> ((disp_uops <= SUM_W'(DISP_W)) || (in_ready == LANES'(1))));

  // R6: pool never rises above its size.
  assert_pool_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (REG_FILE_SIZE == 0) || (int'(reg_free_cnt) <= REG_FILE_SIZE));

  // R7: a reported cause means some valid lane was refused.
  assert_cause_has_refusal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_cause != 3'd0) |-> ((in_valid & ~in_ready) != '0));

  // R8: no stall, no stall counter movement.
  assert_stall_cnt_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_cause == 3'd0) |=> $stable(stall_cnt));

endmodule

bind dispatch_admit dispatch_admit_chk #(
  .LANES        (LANES),
  .DISP_W       (DISP_W),
  .SUM_W        (SUM_W),
  .RCW          (RCW),
  .REG_FILE_SIZE(REG_FILE_SIZE),
  .CNT_W        (CNT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .disp_uops   (disp_uops),
  .stall_cause (stall_cause),
  .reg_free_cnt(reg_free_cnt),
  .stall_cnt   (stall_cnt)
);

// File: tb/dispatch_admit_tb.sv
`timescale 1ns/1ps
module dispatch_admit_tb;
  localparam int L = 4, W = 4, UW = 3, DW = 2, FW = 4, NREG = 8, CW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [L-1:0]      in_valid;
  logic [L*UW-1:0]   in_uops;
  logic [L*DW-1:0]   in_dsts;
  logic [L*2-1:0]    in_kind;
  logic [L-1:0]      in_ready, unb_ready;
  logic [FW-1:0]     rob_free, sched_free, lq_free, sq_free;
  logic              ret_valid;
  logic [DW-1:0]     ret_dsts;
  logic [5:0]        disp_uops, unb_uops;
  logic [4:0]        disp_dsts, unb_dsts;
  logic [2:0]        stall_cause, unb_cause;
  logic [3:0]        reg_free_cnt;
  logic [0:0]        unb_free;
  logic [6*CW-1:0]   stall_cnt, unb_stall;
  logic [5*CW-1:0]   hist_cnt, unb_hist;

  dispatch_admit #(.LANES(L), .DISP_W(W), .UOP_W(UW), .DST_W(DW), .FREE_W(FW),
                   .REG_FILE_SIZE(NREG), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_uops(in_uops), .in_dsts(in_dsts),
    .in_kind(in_kind), .in_ready(in_ready), .rob_free(rob_free), .sched_free(sched_free),
    .lq_free(lq_free), .sq_free(sq_free), .ret_valid(ret_valid), .ret_dsts(ret_dsts),
    .disp_uops(disp_uops), .disp_dsts(disp_dsts), .stall_cause(stall_cause),
    .reg_free_cnt(reg_free_cnt), .stall_cnt(stall_cnt), .hist_cnt(hist_cnt));

  dispatch_admit #(.LANES(L), .DISP_W(W), .UOP_W(UW), .DST_W(DW), .FREE_W(FW),
                   .REG_FILE_SIZE(0), .CNT_W(CW)) u_unb (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_uops(in_uops), .in_dsts(in_dsts),
    .in_kind(in_kind), .in_ready(unb_ready), .rob_free(rob_free), .sched_free(sched_free),
    .lq_free(lq_free), .sq_free(sq_free), .ret_valid(ret_valid), .ret_dsts(ret_dsts),
    .disp_uops(unb_uops), .disp_dsts(unb_dsts), .stall_cause(unb_cause),
    .reg_free_cnt(unb_free), .stall_cnt(unb_stall), .hist_cnt(unb_hist));

  int total = 0, bad = 0;
  int nv, rob_f, sch_f, lq_f, sq_f, rv, rdn;
  int u[L], d[L], k[L];
  int m_reg;
  int m_stall[6];
  int m_hist[W+1];
  int e_mask, e_cause, e_u, e_d;
  int unsigned seed = 32'h2468_ace1;

  function int unsigned rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic drive();
    for (int i = 0; i < L; i++) begin
      in_valid[i]          = (i < nv);
      in_uops[i*UW +: UW]  = UW'(u[i]);
      in_dsts[i*DW +: DW]  = DW'(d[i]);
      in_kind[i*2 +: 2]    = 2'(k[i]);
    end
    rob_free   = FW'(rob_f);
    sched_free = FW'(sch_f);
    lq_free    = FW'(lq_f);
    sq_free    = FW'(sq_f);
    ret_valid  = (rv != 0);
    ret_dsts   = DW'(rdn);
  endtask

  // Reference admission computed from the requirements.
  task automatic model();
    int cu, cd, cl, cs;
    bit live;
    cu = 0; cd = 0; cl = 0; cs = 0; live = 1'b1;
    e_mask = 0; e_cause = 0;
    for (int i = 0; i < L; i++) begin
      if (live && i < nv) begin
        int c;
        int ld, st;
        ld = k[i] & 1;
        st = (k[i] >> 1) & 1;
        c = 0;
        if (cu + u[i] > rob_f)               c = 1;
        else if (cd + d[i] > m_reg)          c = 2;
        else if (cu + u[i] > sch_f)          c = 3;
        else if (ld == 1 && cl + 1 > lq_f)   c = 4;
        else if (st == 1 && cs + 1 > sq_f)   c = 5;
        else if (i > 0 && cu + u[i] > W)     c = 6;
        if (c == 0) begin
          e_mask = e_mask | (1 << i);
          cu = cu + u[i]; cd = cd + d[i]; cl = cl + ld; cs = cs + st;
        end else begin
          e_cause = c;
          live = 1'b0;
        end
      end else begin
        live = 1'b0;
      end
    end
    e_u = cu;
    e_d = cd;
  endtask

  task automatic step();
    drive();
    #1;
    model();
    chk("R1/R2/R3/R4/R5 accept mask", 32'(in_ready), 32'(e_mask));
    chk("R2/R3 admitted uops", 32'(disp_uops), 32'(e_u));
    chk("R4 admitted dests", 32'(disp_dsts), 32'(e_d));
    chk("R7 stall cause", 32'(stall_cause), 32'(e_cause));
    m_reg = m_reg - e_d + ((rv != 0) ? rdn : 0);
    if (e_cause != 0) m_stall[e_cause-1]++;
    m_hist[(e_u > W) ? W : e_u]++;
    @(negedge clk);
    chk("R6 register pool", 32'(reg_free_cnt), 32'(m_reg));
    for (int c = 0; c < 6; c++) chk("R8 stall counter", 32'(stall_cnt[c*CW +: CW]), 32'(m_stall[c]));
    for (int b = 0; b <= W; b++) chk("R9 histogram", 32'(hist_cnt[b*CW +: CW]), 32'(m_hist[b]));
  endtask

  task automatic quiet_fields();
    nv = 0; rv = 0; rdn = 0;
    rob_f = 15; sch_f = 15; lq_f = 3; sq_f = 3;
    for (int i = 0; i < L; i++) begin u[i] = 1; d[i] = 0; k[i] = 0; end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    m_reg = NREG;
    for (int c = 0; c < 6; c++) m_stall[c] = 0;
    for (int b = 0; b <= W; b++) m_hist[b] = 0;
    quiet_fields();
    drive();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state while held in reset
    chk("R10 pool at reset", 32'(reg_free_cnt), NREG);
    chk("R10 stall counters at reset", 32'(|stall_cnt), 0);
    chk("R10 histogram at reset", 32'(|hist_cnt), 0);
    rst_n = 1'b1;
    #1;
    chk("R10 pool after release", 32'(reg_free_cnt), NREG);
    @(negedge clk);
    m_hist[0]++;  // one idle cycle out of reset
    chk("R9 idle cycle bin", 32'(hist_cnt[0 +: CW]), 1);

    // R2 and R3: two-lane micro-op pairs against every reorder-buffer level
    for (int a = 1; a <= 7; a++)
      for (int b = 1; b <= 7; b++)
        for (int rf = 0; rf < 16; rf++) begin
          quiet_fields();
          nv = 2; u[0] = a; u[1] = b; rob_f = rf;
          step();
        end

    // R5: every load/store kind pattern against small queue levels
    for (int kk = 0; kk < 256; kk++)
      for (int lq = 0; lq < 3; lq++)
        for (int sq = 0; sq < 3; sq++) begin
          quiet_fields();
          nv = 4; lq_f = lq; sq_f = sq;
          for (int i = 0; i < L; i++) k[i] = (kk >> (2*i)) & 3;
          step();
        end

    // R5: scheduler levels with mixed micro-op counts
    for (int sf = 0; sf < 16; sf++) begin
      quiet_fields();
      nv = 4; u[0] = 2; u[1] = 1; u[2] = 1; u[3] = 3; rob_f = 15; sch_f = sf;
      step();
    end

    // R2: oversized head goes alone into bin W
    quiet_fields();
    nv = 3; u[0] = 7; u[1] = 1; u[2] = 1;
    step();
    chk("R2 oversized head alone", 32'(in_ready), 1);

    // R4 and R6: drain the pool, then compare bounded and unbounded
    while (m_reg > 0) begin
      quiet_fields();
      nv = 1; d[0] = (m_reg > 3) ? 3 : m_reg;
      step();
    end
    chk("R6 pool drained", 32'(reg_free_cnt), 0);
    quiet_fields();
    nv = 1; d[0] = 1;
    drive();
    #1;
    chk("R4 unbounded pool admits", 32'(unb_ready[0]), 1);
    chk("R4 bounded pool refuses", 32'(stall_cause), 2);
    step();
    while (m_reg < NREG) begin
      quiet_fields();
      rv = 1; rdn = (NREG - m_reg > 3) ? 3 : NREG - m_reg;
      step();
    end
    chk("R6 pool refilled by retire", 32'(reg_free_cnt), NREG);

    // Mixed random traffic covering all requirements together
    for (int n = 0; n < 2500; n++) begin
      nv = int'(rnd() % 5);
      for (int i = 0; i < L; i++) begin
        u[i] = 1 + int'(rnd() % 5);
        d[i] = int'(rnd() % 4);
        k[i] = int'(rnd() % 4);
      end
      rob_f = int'(rnd() % 16);
      sch_f = int'(rnd() % 16);
      lq_f  = int'(rnd() % 3);
      sq_f  = int'(rnd() % 3);
      rv    = int'(rnd() % 2);
      rdn   = int'(rnd() % 4);
      if (rdn > NREG - m_reg) rdn = NREG - m_reg;
      step();
    end

    summary();
    $finish;
  end

endmodule